// File: doc/BRIEF.md
# Cache Control and Invalidate Sequencer

This block holds the control and status registers of a small external-memory cache and owns the sequence that wipes the tag-valid array. Software reaches it over a simple 32-bit register bus with an address, a write enable, write data and combinational read data. The block gives the cache datapath an enable, a bypass, a write-allocate select and a critical-word-first disable. It also drives a clear port into the valid array, which takes one line index per clock.

Writing any value to the invalidate address starts a sweep. The sweep clears every line index in turn, from 0 up to the last line. The last line is set by the `NUM_LINES` parameter. While the sweep runs, the datapath is held in bypass and the ready flag stays low. The software enable bit keeps its value throughout. A sweep also runs on its own after reset, so ready first goes high only when every line is invalid.

Top module: `cachectl_top`

## Requirements
- R1: A read of byte address 0x000 returns the identification word: release number in bits 5:0, part number in bits 9:6, cache identifier in bits 15:10, zeros above.
- R2: A read of address 0x004 returns the size word: cache size in bits 15:0, memory size in bits 31:16.
- R3: At address 0x100, bit 0 (cache enable), bit 1 (write-allocate) and bit 2 (critical-word-first disable) are writable. They read back, and they drive `cache_en_o`, `wr_alloc_o` and `cwf_dis_o` from the cycle after the write. All other bits of that word read 0, except bit 16.
- R4: Bit 16 of the word at 0x100 is the ready flag. It reads 1 exactly when no sweep is running, and writes to it have no effect. `ready_o` carries the same flag.
- R5: A write of any data value to 0x700 starts a sweep. Starting in the cycle after the write, `clr_valid_o` is high for exactly `NUM_LINES` cycles, and `clr_index_o` steps 0, 1, … up to `NUM_LINES-1`.
- R6: While a sweep runs, `bypass_o` is 1 and ready is 0. This holds whether or not the cache is enabled, and the enable bit keeps its value.
- R7: Ready returns to 1, and `bypass_o` to 0, in the cycle after the last clear. `clr_valid_o` is low whenever no sweep runs.
- R8: Reads of 0x700 always return 0.
- R9: Writes to 0x000, 0x004 and to unused addresses have no effect. Reads of unused addresses return 0.
- R10: An invalidate write during a sweep restarts it at index 0. This includes a write in the cycle of the last clear, and in that case ready stays 0.
- R11: While reset is active, and after it, the control bits are 0. A full sweep starts by itself after reset is released, and ready is 0 until that sweep ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| cache_en_o | output | 1 | Cache enable bit to the datapath |
| wr_alloc_o | output | 1 | Write-allocate select |
| cwf_dis_o | output | 1 | Critical-word-first fill disable |
| bypass_o | output | 1 | Forces the datapath into bypass during a sweep |
| ready_o | output | 1 | Ready flag, high when no sweep runs |
| clr_valid_o | output | 1 | Clear strobe for the valid array |
| clr_index_o | output | IDX_W | Line index to clear |

## Verification
The sharpest collision is a new invalidate write landing on the same clock edge as the last line clear of the running sweep. In that case the restart must win, and ready must never pulse high between the two sweeps. The bench times a second invalidate write exactly `NUM_LINES` edges after the first. A scoreboard then expects a seamless run of indices from `NUM_LINES-1` back to 0, with ready held low. A control write issued while a sweep runs is the second overlap. It must update the enable bits at once and leave the sweep untouched.

// File: rtl/cachectl_pkg.sv
package cachectl_pkg;
  // Byte offsets of the register words
  localparam int unsigned OFF_IDENT = 'h000;
  localparam int unsigned OFF_SIZES = 'h004;
  localparam int unsigned OFF_CTRL  = 'h100;
  localparam int unsigned OFF_INVAL = 'h700;

  // Control word bit positions
  localparam int unsigned CTRL_EN_BIT    = 0;
  localparam int unsigned CTRL_WALLOC_BIT = 1;
  localparam int unsigned CTRL_CWFDIS_BIT = 2;
  localparam int unsigned CTRL_READY_BIT  = 16;

  typedef struct packed {
    logic cwf_dis;
    logic wr_alloc;
    logic enable;
  } ctrl_bits_t;
endpackage

// File: rtl/cachectl_sweep.sv
module cachectl_sweep #(
  parameter int unsigned NUM_LINES = 16,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             step_en;

  assign step_en = start_i | busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (start_i) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  // Reset value starts the power-on sweep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (step_en) begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;

  p_start_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && idx_o == '0));

  p_step_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i && idx_o != LAST_IDX) |=> (busy_o && idx_o == $past(idx_o) + 1'b1));

  p_finish_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i && idx_o == LAST_IDX) |=> !busy_o);

  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o && idx_o == '0));
endmodule

// File: rtl/cachectl_regs.sv
module cachectl_regs
  import cachectl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter logic [5:0]  REL_NUM   = 6'h05,
  parameter logic [3:0]  PART_NUM  = 4'h3,
  parameter logic [5:0]  CACHE_TAG = 6'h2A,
  parameter logic [15:0] CACHE_KB  = 16'd16,
  parameter logic [15:0] MEM_KB    = 16'd1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  input  logic              busy_i,
  output logic [31:0]       rdata_o,
  output ctrl_bits_t        ctrl_o,
  output logic              inval_start_o
);
  localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(OFF_IDENT);
  localparam logic [ADDR_W-1:0] A_SIZES = ADDR_W'(OFF_SIZES);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_INVAL = ADDR_W'(OFF_INVAL);
  localparam logic [31:0] IDENT_WORD = {16'h0, CACHE_TAG, PART_NUM, REL_NUM};
  localparam logic [31:0] SIZES_WORD = {MEM_KB, CACHE_KB};

  ctrl_bits_t ctrl_q, ctrl_d;
  logic       ctrl_wr;
  logic       unused_wdata;

  assign unused_wdata = ^wdata_i[31:3];
  assign ctrl_wr       = we_i && (addr_i == A_CTRL);
  assign inval_start_o = we_i && (addr_i == A_INVAL);

  always_comb begin
    ctrl_d          = ctrl_q;
    ctrl_d.enable   = wdata_i[CTRL_EN_BIT];
    ctrl_d.wr_alloc = wdata_i[CTRL_WALLOC_BIT];
    ctrl_d.cwf_dis  = wdata_i[CTRL_CWFDIS_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_IDENT: rdata_o = IDENT_WORD;
      A_SIZES: rdata_o = SIZES_WORD;
      A_CTRL: begin
        rdata_o[CTRL_EN_BIT]     = ctrl_q.enable;
        rdata_o[CTRL_WALLOC_BIT] = ctrl_q.wr_alloc;
        rdata_o[CTRL_CWFDIS_BIT] = ctrl_q.cwf_dis;
        rdata_o[CTRL_READY_BIT]  = !busy_i;
      end
      default: rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;

  p_ctrl_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ctrl_o));

  p_inval_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_INVAL) |-> (rdata_o == '0));
endmodule

// File: rtl/cachectl_top.sv
module cachectl_top
  import cachectl_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned ADDR_W    = 12,
  localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              cache_en_o,
  output logic              wr_alloc_o,
  output logic              cwf_dis_o,
  output logic              bypass_o,
  output logic              ready_o,
  output logic              clr_valid_o,
  output logic [IDX_W-1:0]  clr_index_o
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        inval_start;
  logic        busy;
  ctrl_bits_t  ctrl;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cachectl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_int_n),
    .addr_i        (bus_addr_i),
    .we_i          (bus_we_i),
    .wdata_i       (bus_wdata_i),
    .busy_i        (busy),
    .rdata_o       (bus_rdata_o),
    .ctrl_o        (ctrl),
    .inval_start_o (inval_start)
  );

  cachectl_sweep #(.NUM_LINES(NUM_LINES)) u_sweep (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .start_i (inval_start),
    .busy_o  (busy),
    .idx_o   (clr_index_o)
  );

  assign cache_en_o  = ctrl.enable;
  assign wr_alloc_o  = ctrl.wr_alloc;
  assign cwf_dis_o   = ctrl.cwf_dis;
  assign bypass_o    = busy;
  assign ready_o     = !busy;
  assign clr_valid_o = busy;

  p_ready_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (bus_addr_i == ADDR_W'(OFF_CTRL)) |-> (bus_rdata_o[CTRL_READY_BIT] == !clr_valid_o));

  p_bypass_in_sweep_r6: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    clr_valid_o |-> (bypass_o && !ready_o));

  p_enable_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (clr_valid_o && !bus_we_i) |=> $stable(cache_en_o));
endmodule

// File: tb/cachectl_top_bench.sv
module cachectl_top_bench;
  localparam int NL   = 16;
  localparam int IW   = $clog2(NL);
  localparam int AW   = 12;
  localparam logic [AW-1:0] A_ID  = 12'h000;
  localparam logic [AW-1:0] A_SZ  = 12'h004;
  localparam logic [AW-1:0] A_CT  = 12'h100;
  localparam logic [AW-1:0] A_INV = 12'h700;
  localparam logic [31:0] EXP_ID = {16'h0, 6'h2A, 4'h3, 6'h05};
  localparam logic [31:0] EXP_SZ = {16'd1024, 16'd16};

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr;
  logic we;
  logic [31:0] wdata, rdata;
  logic en_o, wa_o, cwf_o, byp_o, rdy_o, clr_v;
  logic [IW-1:0] clr_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_en  = 1'b0;
  int exp_q[$];

  always #2 clk = ~clk;

  cachectl_top #(.NUM_LINES(NL), .ADDR_W(AW)) u_cachectl_top (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .cache_en_o(en_o),
    .wr_alloc_o(wa_o), .cwf_dis_o(cwf_o), .bypass_o(byp_o),
    .ready_o(rdy_o), .clr_valid_o(clr_v), .clr_index_o(clr_i)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_sweep();
    exp_q.delete();
    for (int i = 0; i < NL; i++) exp_q.push_back(i);
  endtask

  task automatic bus_write(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    if (a == A_INV) load_sweep();
    #1 we = 1'b0;
  endtask

  task automatic bus_read(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (2) @(posedge clk);
  endtask

  // Monitor: scoreboard of clear indices, ready and bypass (R5 R6 R7 R10 R11)
  always @(posedge clk) begin
    #1;
    if (mon_en) begin
      if (clr_v) begin
        if (exp_q.size() == 0) chk("R7 unexpected clear", 32'(clr_i), 32'hFFFF_FFFF);
        else chk("R5 clear index", 32'(clr_i), 32'(exp_q.pop_front()));
        chk("R6 ready low in sweep", 32'(rdy_o), 32'd0);
        chk("R6 bypass in sweep", 32'(byp_o), 32'd1);
      end else begin
        chk("R7 no clear pending", 32'(exp_q.size()), 32'd0);
        chk("R7 ready after sweep", 32'(rdy_o), 32'd1);
        chk("R7 bypass off", 32'(byp_o), 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    // R11: reset state
    bus_read(A_CT, r);
    chk("R11 ctrl word in reset", r, 32'h0);
    chk("R11 enable in reset", 32'(en_o), 32'd0);
    chk("R11 ready low in reset", 32'(rdy_o), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    load_sweep();
    mon_en = 1'b1;
    bus_read(A_CT, r);
    chk("R11 ready low during boot sweep", r, 32'h0);
    wait_idle();
    chk("R11 boot sweep complete", 32'(exp_q.size()), 32'd0);

    bus_read(A_ID, r);  chk("R1 ident word", r, EXP_ID);
    bus_read(A_SZ, r);  chk("R2 size word", r, EXP_SZ);
    bus_read(A_CT, r);  chk("R4 ready idle", r, 32'h0001_0000);

    bus_write(A_CT, 32'h0000_0005);
    chk("R3 enable out", 32'(en_o), 32'd1);
    chk("R3 walloc out", 32'(wa_o), 32'd0);
    chk("R3 cwf out", 32'(cwf_o), 32'd1);
    bus_write(A_CT, 32'hFFFE_FFFA);
    chk("R3 walloc set", 32'(wa_o), 32'd1);
    bus_read(A_CT, r);  chk("R3 R4 masked readback", r, 32'h0001_0002);
    bus_write(A_CT, 32'hFFFF_FFFF);
    bus_read(A_CT, r);  chk("R4 ready not writable", r, 32'h0001_0007);

    // R9: read-only and unused addresses
    bus_write(A_ID, 32'h0);
    bus_write(A_SZ, 32'hFFFF_FFFF);
    bus_write(12'h008, 32'h0);
    bus_write(12'h104, 32'h0);
    bus_read(A_ID, r);     chk("R9 ident unchanged", r, EXP_ID);
    bus_read(A_SZ, r);     chk("R9 sizes unchanged", r, EXP_SZ);
    bus_read(A_CT, r);     chk("R9 ctrl unchanged", r, 32'h0001_0007);
    bus_read(12'h104, r);  chk("R9 unused reads zero", r, 32'h0);
    bus_read(12'h6FC, r);  chk("R9 unused reads zero high", r, 32'h0);

    // R5 R6 R8: invalidate with cache enabled
    bus_write(A_INV, 32'hDEAD_BEEF);
    chk("R6 enable kept in sweep", 32'(en_o), 32'd1);
    bus_read(A_INV, r);  chk("R8 invalidate reads zero", r, 32'h0);
    bus_read(A_CT, r);   chk("R6 ctrl during sweep", r, 32'h0000_0007);
    bus_write(A_CT, 32'h0000_0002);
    chk("R3 ctrl write during sweep", 32'(en_o), 32'd0);
    wait_idle();
    bus_read(A_CT, r);   chk("R4 ready after sweep", r, 32'h0001_0002);

    // R10: restart mid-sweep
    bus_write(A_INV, 32'h0);
    repeat (5) @(posedge clk);
    bus_write(A_INV, 32'h1234_5678);
    wait_idle();

    // R10: restart on the edge of the last clear
    bus_write(A_INV, 32'h0);
    repeat (NL - 1) @(posedge clk);
    bus_write(A_INV, 32'hFFFF_FFFF);
    wait_idle();
    chk("R10 sweeps drained", 32'(exp_q.size()), 32'd0);

    mon_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule